// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Cell

This block is one logic cell of a coarse-grained programmable fabric. It holds two small lookup tables. Each table is addressed by three data inputs and returns two bits, so one cell does the work of four independent 3-input functions. Three inputs address the first table and the other three address the second. The four results leave the cell either directly or through a flip-flop, chosen per output.

The cell's contents arrive over a one-bit serial configuration path, one bit per clock, while a load strobe is held high. For arithmetic, a configuration bit turns the first table into a propagate/generate pair. In that mode the cell forms a sum bit and drives a dedicated carry output straight into the carry input of the neighbouring cell. A ripple adder can then span several cells without any general routing.

Top module: `dual_lut_cell`

## Requirements
- R1: After reset every configuration bit is zero, so all four outputs and `carry_out` read 0 whatever the data inputs and `carry_in` are.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into bit 0 of a 37-bit configuration word, and every bit already held moves one place up. The first bit sent therefore ends in bit 36. The word holds the truth table of o1 in bits 7:0, o2 in 15:8, o3 in 23:16 and o4 in 31:24. Bit 32 is carry mode. Bits 36:33 are the register selects, with bit 33 for o1 and bit 36 for o4.
- R3: Table 0 is addressed by `lut_in[2:0]` (a = bit 0, the address LSB). With carry mode off, o1 = cfg[addr] and o2 = cfg[8+addr].
- R4: Table 1 is addressed by `lut_in[5:3]` (d = bit 3, the LSB). o3 = cfg[16+addr] and o4 = cfg[24+addr]. Neither table depends on the other table's inputs.
- R5: With carry mode on, the o1 entry of table 0 acts as generate g and the o2 entry as propagate p. o2 = p XOR `carry_in`, `carry_out` = p ? `carry_in` : g, and o1 still shows g.
- R6: With carry mode off, `carry_out` is 0 and `carry_in` has no effect on any output.
- R7: Four cells chained carry_out to carry_in, each configured with g = a AND b and p = a XOR b, produce the 5-bit sum of two 4-bit operands plus the first cell's carry-in, with no clock edge involved.
- R8: At each rising edge with `cfg_en` low, each output's flip-flop captures that output's unregistered value. An output whose register select is set shows the flip-flop, so it lags one clock.
- R9: While `cfg_en` is high, all four outputs and `carry_out` read 0 and the output flip-flops keep their contents.
- R10: Reset is synchronous and active low. It clears the configuration word and the flip-flops only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the output flip-flops |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Configuration shift strobe; blanks outputs while high |
| cfg_din | input | 1 | Serial configuration bit |
| lut_in | input | 6 | Data inputs a..f; bits 2:0 address table 0, bits 5:3 address table 1 |
| carry_in | input | 1 | Carry from the preceding cell |
| lut_out | output | 4 | Outputs o1..o4 in bits 0..3 |
| carry_out | output | 1 | Carry to the following cell |

## Verification
Every table is driven through all 64 input combinations against several configuration words: random words plus the all-zero and all-one words. A bit-order slip in the serial load, or a swap between the two tables' address inputs, shows up as a wrong output at some address. A single set bit in a word pins down the MSB-first ordering directly. The carry path is tested with random carry-in, both with carry mode on and with it off. A design that leaks `carry_in` when the mode is off, or that inverts the carry mux, fails there. A 4-cell ripple adder is then compared against integer addition. Registered outputs are sampled just before and just after an edge, which catches a missing or doubled stage. The bench also checks that the flip-flops hold their value across a full reload and that a reset asserted between edges has no effect until the next edge.

// File: rtl/dlc_pkg.sv
// Shared sizes of the dual-LUT cell. Every width below derives from
// the table geometry; assumes one carry-mode bit and one register
// select per output, placed above the truth tables.
package dlc_pkg;
    localparam int LUT_IN     = 3;
    localparam int LUT_OUT    = 2;
    localparam int NUM_LUT    = 2;
    localparam int LUT_DEPTH  = 1 << LUT_IN;
    localparam int TBL_BITS   = LUT_OUT * LUT_DEPTH;
    localparam int NUM_IN     = NUM_LUT * LUT_IN;
    localparam int NUM_OUT    = NUM_LUT * LUT_OUT;
    localparam int CARRY_BIT  = NUM_LUT * TBL_BITS;
    localparam int REGSEL_LSB = CARRY_BIT + 1;
    localparam int CFG_BITS   = REGSEL_LSB + NUM_OUT;
endpackage

// File: rtl/dlc_cfg_chain.sv
// Serial configuration register. Shifts din into bit 0 while shift_en
// is high, so the first bit sent lands in the top bit. Assumes the
// caller keeps shift_en high for exactly WIDTH edges per load.
module dlc_cfg_chain #(
    parameter int WIDTH = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    // Purpose: clear on reset, otherwise shift one bit per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[WIDTH-2:0], din};
    end
endmodule

// File: rtl/dlc_lut.sv
// One multi-output lookup table. Output j reads its own DEPTH-bit
// truth table at the shared address. Purely combinational; assumes
// the table bits are static while the result is used.
module dlc_lut #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2,
    localparam int DEPTH = 1 << N_IN
) (
    input  logic [N_OUT*DEPTH-1:0] table_bits,
    input  logic [N_IN-1:0]        addr,
    output logic [N_OUT-1:0]       dout
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_col
        logic [DEPTH-1:0] column;
        // Purpose: slice this output's truth table and index it.
        always_comb begin
            column  = table_bits[j*DEPTH +: DEPTH];
            dout[j] = column[addr];
        end
    end
endmodule

// File: rtl/dlc_carry.sv
// Carry logic of one cell: sum bit from propagate and carry-in, and
// carry-out as a propagate-steered mux. Assumes gen/prop come from
// the first table; drives 0 carry-out when the mode is off.
module dlc_carry (
    input  logic mode,
    input  logic gen,
    input  logic prop,
    input  logic cin,
    output logic sum_bit,
    output logic cout
);
    // Purpose: form the sum bit and steer the carry.
    always_comb begin
        sum_bit = prop ^ cin;
        cout    = mode ? (prop ? cin : gen) : 1'b0;
    end
endmodule

// File: rtl/dlc_out_stage.sv
// Per-output register stage. Each bit has a flip-flop that samples
// its input whenever hold is low; a select bit picks flip-flop or
// direct value. While hold is high every output reads 0.
module dlc_out_stage #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] dout
);
    // Purpose: synchronous clear, capture unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!hold)
            q <= d;
    end

    for (genvar j = 0; j < N; j++) begin : g_bit
        // Purpose: blank during load, else pick registered or direct.
        always_comb dout[j] = hold ? 1'b0 : (sel[j] ? q[j] : d[j]);
    end
endmodule

// File: rtl/dual_lut_cell.sv
// Dual-LUT logic cell: two 3-in/2-out tables, optional carry mode on
// table 0 and per-output registers. Configured serially; assumes the
// outputs are not used while cfg_en is high.
module dual_lut_cell
    import dlc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_din,
    input  logic [NUM_IN-1:0]  lut_in,
    input  logic               carry_in,
    output logic [NUM_OUT-1:0] lut_out,
    output logic               carry_out
);
    logic [CFG_BITS-1:0] cfg_word;
    logic [NUM_OUT-1:0]  lut_raw;
    logic [NUM_OUT-1:0]  cell_val;
    logic [NUM_OUT-1:0]  ff_q;
    logic                carry_mode;
    logic                sum_bit;
    logic                cout_raw;

    dlc_cfg_chain #(.WIDTH(CFG_BITS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .word     (cfg_word)
    );

    for (genvar t = 0; t < NUM_LUT; t++) begin : g_lut
        dlc_lut #(.N_IN(LUT_IN), .N_OUT(LUT_OUT)) u_lut (
            .table_bits (cfg_word[t*TBL_BITS +: TBL_BITS]),
            .addr       (lut_in[t*LUT_IN +: LUT_IN]),
            .dout       (lut_raw[t*LUT_OUT +: LUT_OUT])
        );
    end

    assign carry_mode = cfg_word[CARRY_BIT];

    dlc_carry u_carry (
        .mode    (carry_mode),
        .gen     (lut_raw[0]),
        .prop    (lut_raw[1]),
        .cin     (carry_in),
        .sum_bit (sum_bit),
        .cout    (cout_raw)
    );

    // Purpose: replace o2 with the sum bit in carry mode.
    always_comb begin
        cell_val    = lut_raw;
        cell_val[1] = carry_mode ? sum_bit : lut_raw[1];
    end

    dlc_out_stage #(.N(NUM_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cfg_en),
        .sel   (cfg_word[REGSEL_LSB +: NUM_OUT]),
        .d     (cell_val),
        .q     (ff_q),
        .dout  (lut_out)
    );

    // Purpose: blank the neighbour carry while configuring.
    assign carry_out = cfg_en ? 1'b0 : cout_raw;
endmodule

// File: rtl/dlc_checker.sv
// Property checker for dual_lut_cell, bound to every instance.
module dlc_checker
    import dlc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_en,
    input logic                cfg_din,
    input logic [CFG_BITS-1:0] cfg_word,
    input logic [NUM_OUT-1:0]  cell_val,
    input logic [NUM_OUT-1:0]  ff_q,
    input logic [NUM_OUT-1:0]  lut_out,
    input logic                carry_in,
    input logic                carry_out
);
    logic carry_mode;
    assign carry_mode = cfg_word[CARRY_BIT];

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_word == {$past(cfg_word[CFG_BITS-2:0]), $past(cfg_din)});

    p_cfg_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_word));

    p_carry_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_mode && !cfg_en) |->
            carry_out == ((cell_val[1] ^ carry_in) ? carry_in : cell_val[0]));

    p_carry_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_mode |-> !carry_out);

    p_ff_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_en)) |-> ff_q == $past(cell_val));

    p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (lut_out == '0 && !carry_out));

    p_ff_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_en)) |-> $stable(ff_q));

    p_ff_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ff_q == '0 && cfg_word == '0));
endmodule

bind dual_lut_cell dlc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_din   (cfg_din),
    .cfg_word  (cfg_word),
    .cell_val  (cell_val),
    .ff_q      (ff_q),
    .lut_out   (lut_out),
    .carry_in  (carry_in),
    .carry_out (carry_out)
);

// File: tb/test_dual_lut_cell.sv
module test_dual_lut_cell;
    localparam int CFGN = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic [3:0] cfg_din_v = '0;
    logic [5:0] xin [4];
    logic       cin0 = 1'b0;
    logic [3:0] out_v [4];
    logic [3:0] cout_v;
    logic [CFGN-1:0] wv [4];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    for (genvar k = 0; k < 4; k++) begin : g_cell
        logic cin_k;
        if (k == 0) begin : g_first
            assign cin_k = cin0;
        end else begin : g_next
            assign cin_k = cout_v[k-1];
        end
        dual_lut_cell i_dual_lut_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_en    (cfg_en),
            .cfg_din   (cfg_din_v[k]),
            .lut_in    (xin[k]),
            .carry_in  (cin_k),
            .lut_out   (out_v[k]),
            .carry_out (cout_v[k])
        );
    end

    // Reference: returns {cout, o4, o3, o2, o1} for unregistered outputs.
    function automatic logic [4:0] ref_eval(input logic [CFGN-1:0] w,
                                            input logic [5:0] x, input logic c);
        logic [2:0] a0, a1;
        logic g, p, o2, o3, o4, co;
        a0 = x[2:0];
        a1 = x[5:3];
        g  = w[a0];
        p  = w[8 + a0];
        o3 = w[16 + a1];
        o4 = w[24 + a1];
        if (w[32]) begin
            o2 = p ^ c;
            co = p ? c : g;
        end else begin
            o2 = p;
            co = 1'b0;
        end
        return {co, o4, o3, o2, g};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_all(input bit probe);
        for (int i = CFGN - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            for (int k = 0; k < 4; k++) cfg_din_v[k] = wv[k][i];
            if (probe && i == 18) begin
                xin[0] = ~xin[0];
                cin0 = ~cin0;
                #2;
                chk("R9 outputs blank while loading", int'(out_v[0]), 0);
                chk("R9 carry blank while loading", int'(cout_v[0]), 0);
            end
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic reg_run(input logic [3:0] mask, output logic [3:0] last);
        logic [4:0] prev, cur;
        logic [3:0] expv;
        wv[0] = {mask, 1'b0, 32'($urandom)};
        load_all(1'b0);
        xin[0] = 6'($urandom);
        @(posedge clk);
        #1;
        prev = ref_eval(wv[0], xin[0], cin0);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            xin[0] = 6'($urandom);
            #2;
            cur = ref_eval(wv[0], xin[0], cin0);
            for (int j = 0; j < 4; j++) expv[j] = mask[j] ? prev[j] : cur[j];
            chk("R8 before capture edge", int'(out_v[0]), int'(expv));
            @(posedge clk);
            #1;
            chk("R8 after capture edge", int'(out_v[0]), int'(cur[3:0]));
            prev = cur;
        end
        last = prev[3:0];
    endtask

    initial begin
        logic [4:0] e;
        logic [3:0] held;
        logic [4:0] s;
        logic [3:0] xa, ya;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) begin
            xin[k] = '0;
            wv[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        xin[0] = 6'h2d;
        cin0 = 1'b1;
        #2;
        chk("R1 outputs after reset", int'(out_v[0]), 0);
        chk("R1 carry after reset", int'(cout_v[0]), 0);

        // R2: single set bits locate the MSB-first bit order.
        wv[0] = (37'd1 << 5) | (37'd1 << 26);
        load_all(1'b0);
        xin[0] = 6'd5;
        #2 chk("R2 o1 at address 5", int'(out_v[0]), 4'b0001);
        @(negedge clk); xin[0] = 6'd16;
        #2 chk("R2 o4 at address 2", int'(out_v[0]), 4'b1000);
        @(negedge clk); xin[0] = 6'd21;
        #2 chk("R2 both tables", int'(out_v[0]), 4'b1001);

        // R3/R4/R5/R6: exhaustive sweep over several tables.
        for (int tr = 0; tr < 8; tr++) begin
            logic [31:0] tb_bits;
            tb_bits = (tr == 0) ? 32'h0 : (tr == 1) ? 32'hffff_ffff : $urandom;
            wv[0] = {4'b0, 1'(tr % 2), tb_bits};
            load_all(1'b0);
            for (int x = 0; x < 64; x++) begin
                @(negedge clk);
                xin[0] = 6'(x);
                cin0 = 1'($urandom);
                #2;
                e = ref_eval(wv[0], xin[0], cin0);
                if (wv[0][32]) begin
                    chk("R5 carry mode outputs R3 R4", int'(out_v[0]), int'(e[3:0]));
                    chk("R5 carry out", int'(cout_v[0]), int'(e[4]));
                end else begin
                    chk("R3 R4 table outputs", int'(out_v[0]), int'(e[3:0]));
                    chk("R6 carry out off", int'(cout_v[0]), 0);
                end
            end
        end

        // R8: registered outputs, partial and full masks.
        reg_run(4'b0101, held);
        reg_run(4'b1111, held);

        // R9: reload the same word; flops must survive the load.
        load_all(1'b1);
        #2 chk("R9 flops held across load", int'(out_v[0]), int'(held));

        // R10: reset is only sampled at the clock edge.
        rst_n = 1'b0;
        #1 chk("R10 no effect before edge", int'(out_v[0]), int'(held));
        @(posedge clk);
        #1 chk("R10 cleared at edge", int'(out_v[0]), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: four-cell ripple adder.
        for (int k = 0; k < 4; k++)
            wv[k] = {4'b0, 1'b1, 16'($urandom), 8'h66, 8'h88};
        load_all(1'b0);
        for (int n = 0; n < 120; n++) begin
            @(negedge clk);
            xa = 4'($urandom);
            ya = 4'($urandom);
            if (n == 0) begin xa = 4'hf; ya = 4'h0; end
            if (n == 1) begin xa = 4'hf; ya = 4'hf; end
            cin0 = (n < 2) ? 1'b1 : 1'($urandom);
            for (int k = 0; k < 4; k++)
                xin[k] = {3'($urandom), 1'($urandom), ya[k], xa[k]};
            #2;
            s = {cout_v[3], out_v[3][1], out_v[2][1], out_v[1][1], out_v[0][1]};
            chk("R7 chained sum", int'(s), int'(xa) + int'(ya) + int'(cin0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule